// File: doc/BRIEF.md
# Variable-Length Two-Operand Instruction Decoder

This block turns a stream of instruction bytes, taken one per clock over a valid/ready handshake, into one decoded record per instruction for a single two-operand addition family. The first byte carries the opcode and an operand-size bit. The second byte is a packed mode byte that chooses between register, memory and immediate operands and says which side is the destination. Between zero and four trailing bytes follow, for an address or displacement and for immediate data. How many there are depends on the mode and on the size bit.

When the last byte of an instruction has arrived, the decoder presents a record that holds steady until the consumer accepts it. The record gives the operand kinds, register codes, address or displacement, immediate value, total length and an illegal flag. The decoder does not execute the addition, compute flags, touch memory or resolve the pointer register used by indirect forms.

Top module: `opx_decoder`

## Requirements
- R1: A first byte whose upper seven bits are not 1000100 ends the instruction at once: the record has length 1 and the illegal flag set.
- R2: Bit 0 of the first byte selects the size (0 = 8-bit, 1 = 16-bit) and is reported on `out_wide`. With 8-bit size the immediate is one byte and is zero-extended to 16 bits. An address or displacement is two bytes for either size.
- R3: A mode byte with bits 7:6 = 00 is register to register: source register code in bits 5:3, destination register code in bits 2:0, with no trailing bytes.
- R4: Bits 7:6 = 01 name a register destination (bits 2:0). Bit 3 = 1 with bits 5:4 = 00 means an immediate source. Bit 3 = 0 gives a memory source whose form is set by bits 5:4: 00 direct (2 address bytes), 01 indirect (none), 10 indirect with offset (2 displacement bytes). Kind codes are 0 register, 1 immediate, 2 direct memory, 3 indirect memory, 4 indirect memory with offset, 7 none.
- R5: Bits 7:6 = 11 name a memory destination whose form is set by bits 5:4. Bit 3 = 0 gives a register source with its code in bits 2:0. Bit 3 = 1 gives an immediate source.
- R6: Trailing bytes arrive low byte first. The address or displacement comes before the immediate data.
- R7: `out_len` gives the total number of bytes in the instruction, from 1 to 6.
- R8: Mode bits 7:6 = 10, a memory form of 11, an immediate-to-register mode with nonzero bits 5:4, and an immediate-to-memory mode with nonzero bits 2:0 all end the instruction after the mode byte with length 2. Such a record has the illegal flag set, all fields zero and both kinds 7.
- R9: With 16-bit size, a register operand code of 5, 6 or 7 makes the instruction illegal after the mode byte.
- R10: `out_done` pulses for one cycle as the record appears. The record and `out_valid` hold, with `in_ready` low so that no byte is taken, until `out_accept`. After that the next byte is treated as an opcode.
- R11: A synchronous high `rst` discards any partly collected instruction. The decoder then waits for an opcode byte, with `out_valid` low and `in_ready` high.
- R12: Cycles with `in_valid` low between bytes change nothing and produce no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction byte offered |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Decoder can take a byte |
| out_valid | output | 1 | Decoded record present |
| out_done | output | 1 | One-cycle pulse when the record appears |
| out_accept | input | 1 | Consumer takes the record |
| out_illegal | output | 1 | Instruction not decodable |
| out_wide | output | 1 | 16-bit operands |
| out_dst_kind | output | 3 | Destination kind code |
| out_src_kind | output | 3 | Source kind code |
| out_dst_reg | output | 3 | Destination register code |
| out_src_reg | output | 3 | Source register code |
| out_addr | output | 16 | Address or displacement |
| out_imm | output | 16 | Immediate value |
| out_len | output | 3 | Total instruction length in bytes |

## Verification
The hardest state to reach from the ports is a record that sits unaccepted while the producer keeps offering bytes. In that state the decoder must take none of them, and after acceptance it must treat the next byte as an opcode. The bench holds back the accept for several cycles, keeps a stray byte on the input the whole time, and then decodes a fresh instruction. A reset that arrives part way through the six-byte form is also driven, followed by a short instruction that has to decode cleanly. The vector walk inserts idle cycles between bytes on every other instruction.

// File: rtl/opx_pkg.sv
package opx_pkg;

   typedef enum logic [2:0] {
      K_REG  = 3'd0,
      K_IMM  = 3'd1,
      K_MDIR = 3'd2,
      K_MIND = 3'd3,
      K_MOFF = 3'd4,
      K_NONE = 3'd7
   } kind_e;

   typedef enum logic [1:0] {
      ST_OPC,
      ST_MODE,
      ST_TAIL,
      ST_HOLD
   } st_e;

   typedef struct packed {
      logic       legal;
      kind_e      dst_kind;
      kind_e      src_kind;
      logic [2:0] dst_reg;
      logic [2:0] src_reg;
      logic       has_addr;
      logic [1:0] imm_bytes;
      logic [2:0] tail_len;
   } dec_t;

   localparam dec_t DEC_IDLE = '{legal: 1'b0, dst_kind: K_NONE, src_kind: K_NONE,
                                 dst_reg: 3'd0, src_reg: 3'd0, has_addr: 1'b0,
                                 imm_bytes: 2'd0, tail_len: 3'd0};

endpackage

// File: rtl/opx_mode_dec.sv
module opx_mode_dec
   import opx_pkg::*;
#(
   parameter int STRICT_WIDE_REGS = 1,
   parameter int WIDE_REG_COUNT   = 5
) (
   input  logic       wide,
   input  logic [7:0] mode,
   output dec_t       dec
);

   dec_t       raw;
   logic [1:0] form;
   logic       form_ok;
   logic       form_addr;
   kind_e      mem_kind;
   logic [1:0] imm_n;
   logic       bad_reg;

   assign form      = mode[5:4];
   assign form_ok   = (form != 2'b11);
   assign form_addr = (form == 2'b00) || (form == 2'b10);
   assign imm_n     = wide ? 2'd2 : 2'd1;

   always_comb begin
      case (form)
         2'b00:   mem_kind = K_MDIR;
         2'b01:   mem_kind = K_MIND;
         2'b10:   mem_kind = K_MOFF;
         default: mem_kind = K_NONE;
      endcase
   end

   always_comb begin
      raw = DEC_IDLE;
      case (mode[7:6])
         2'b00: begin
            raw.legal    = 1'b1;
            raw.dst_kind = K_REG;
            raw.src_kind = K_REG;
            raw.dst_reg  = mode[2:0];
            raw.src_reg  = mode[5:3];
         end
         2'b01: begin
            raw.dst_kind = K_REG;
            raw.dst_reg  = mode[2:0];
            if (mode[3]) begin
               raw.legal     = (form == 2'b00);
               raw.src_kind  = K_IMM;
               raw.imm_bytes = imm_n;
               raw.tail_len  = {1'b0, imm_n};
            end else begin
               raw.legal    = form_ok;
               raw.src_kind = mem_kind;
               raw.has_addr = form_addr;
               raw.tail_len = form_addr ? 3'd2 : 3'd0;
            end
         end
         2'b11: begin
            raw.dst_kind = mem_kind;
            raw.has_addr = form_addr;
            if (mode[3]) begin
               raw.legal     = form_ok && (mode[2:0] == 3'b000);
               raw.src_kind  = K_IMM;
               raw.imm_bytes = imm_n;
               raw.tail_len  = (form_addr ? 3'd2 : 3'd0) + {1'b0, imm_n};
            end else begin
               raw.legal    = form_ok;
               raw.src_kind = K_REG;
               raw.src_reg  = mode[2:0];
               raw.tail_len = form_addr ? 3'd2 : 3'd0;
            end
         end
         default: raw = DEC_IDLE;
      endcase
   end

   generate
      if (STRICT_WIDE_REGS != 0) begin : g_strict
         assign bad_reg = wide &&
            (((raw.dst_kind == K_REG) && (int'(raw.dst_reg) >= WIDE_REG_COUNT)) ||
             ((raw.src_kind == K_REG) && (int'(raw.src_reg) >= WIDE_REG_COUNT)));
      end else begin : g_loose
         assign bad_reg = 1'b0;
      end
   endgenerate

   assign dec = (raw.legal && !bad_reg) ? raw : DEC_IDLE;

endmodule

// File: rtl/opx_tail_buf.sv
module opx_tail_buf #(
   parameter int BYTE_W = 8,
   parameter int SLOTS  = 4
) (
   input  logic                     clk,
   input  logic                     wr_en,
   input  logic [$clog2(SLOTS)-1:0] wr_idx,
   input  logic [BYTE_W-1:0]        wr_data,
   input  logic                     has_addr,
   input  logic [1:0]               imm_bytes,
   output logic [2*BYTE_W-1:0]      addr,
   output logic [2*BYTE_W-1:0]      imm
);

   localparam int IDX_W = $clog2(SLOTS);

   logic [BYTE_W-1:0] slot [SLOTS];
   logic [IDX_W-1:0]  base;

   generate
      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
         always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDX_W'(s))) begin
               slot[s] <= wr_data;
            end
         end
      end
   endgenerate

   assign base = has_addr ? IDX_W'(2) : IDX_W'(0);
   assign addr = has_addr ? {slot[1], slot[0]} : '0;

   always_comb begin
      case (imm_bytes)
         2'd1:    imm = {{BYTE_W{1'b0}}, slot[base]};
         2'd2:    imm = {slot[base + IDX_W'(1)], slot[base]};
         default: imm = '0;
      endcase
   end

endmodule

// File: rtl/opx_decoder.sv
module opx_decoder
   import opx_pkg::*;
#(
   parameter int                BYTE_W           = 8,
   parameter logic [BYTE_W-2:0] OPCODE_STEM      = 7'b1000100,
   parameter int                MAX_LEN          = 6,
   parameter int                STRICT_WIDE_REGS = 1,
   parameter int                WIDE_REG_COUNT   = 5,
   localparam int               FIELD_W          = 2 * BYTE_W,
   localparam int               LEN_W            = $clog2(MAX_LEN + 1)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               in_valid,
   input  logic [BYTE_W-1:0]  in_byte,
   output logic               in_ready,
   output logic               out_valid,
   output logic               out_done,
   input  logic               out_accept,
   output logic               out_illegal,
   output logic               out_wide,
   output logic [2:0]         out_dst_kind,
   output logic [2:0]         out_src_kind,
   output logic [2:0]         out_dst_reg,
   output logic [2:0]         out_src_reg,
   output logic [FIELD_W-1:0] out_addr,
   output logic [FIELD_W-1:0] out_imm,
   output logic [LEN_W-1:0]   out_len
);

   localparam int SLOTS = MAX_LEN - 2;
   localparam int IDX_W = $clog2(SLOTS);

   generate
      if (BYTE_W < 8) begin : g_chk_byte
         $error("opx_decoder: BYTE_W must be at least 8");
      end
      if (MAX_LEN != 6) begin : g_chk_len
         $error("opx_decoder: the longest form needs MAX_LEN of 6");
      end
      if (WIDE_REG_COUNT < 1 || WIDE_REG_COUNT > 8) begin : g_chk_regs
         $error("opx_decoder: WIDE_REG_COUNT must lie in 1..8");
      end
   endgenerate

   st_e              st_q;
   dec_t             dec_q;
   dec_t             dec_w;
   logic             wide_q;
   logic             ill_q;
   logic             done_q;
   logic [LEN_W-1:0] len_q;
   logic [IDX_W-1:0] cnt_q;
   logic             take;
   logic             tail_last;
   logic [FIELD_W-1:0] buf_addr;
   logic [FIELD_W-1:0] buf_imm;

   assign in_ready  = (st_q != ST_HOLD);
   assign take      = in_valid && in_ready;
   assign tail_last = ({1'b0, cnt_q} == (dec_q.tail_len - 3'd1));

   opx_mode_dec #(
      .STRICT_WIDE_REGS (STRICT_WIDE_REGS),
      .WIDE_REG_COUNT   (WIDE_REG_COUNT)
   ) i_mode_dec (
      .wide (wide_q),
      .mode (in_byte[7:0]),
      .dec  (dec_w)
   );

   opx_tail_buf #(
      .BYTE_W (BYTE_W),
      .SLOTS  (SLOTS)
   ) i_tail_buf (
      .clk       (clk),
      .wr_en     (take && (st_q == ST_TAIL)),
      .wr_idx    (cnt_q),
      .wr_data   (in_byte),
      .has_addr  (dec_q.has_addr),
      .imm_bytes (dec_q.imm_bytes),
      .addr      (buf_addr),
      .imm       (buf_imm)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= ST_OPC;
         dec_q  <= DEC_IDLE;
         wide_q <= 1'b0;
         ill_q  <= 1'b0;
         done_q <= 1'b0;
         len_q  <= '0;
         cnt_q  <= '0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            ST_OPC: begin
               if (take) begin
                  wide_q <= in_byte[0];
                  dec_q  <= DEC_IDLE;
                  if (in_byte[BYTE_W-1:1] == OPCODE_STEM) begin
                     st_q <= ST_MODE;
                  end else begin
                     st_q   <= ST_HOLD;
                     ill_q  <= 1'b1;
                     len_q  <= LEN_W'(1);
                     done_q <= 1'b1;
                  end
               end
            end
            ST_MODE: begin
               if (take) begin
                  dec_q <= dec_w;
                  cnt_q <= '0;
                  ill_q <= !dec_w.legal;
                  len_q <= LEN_W'(2) + LEN_W'(dec_w.tail_len);
                  if (!dec_w.legal || (dec_w.tail_len == 3'd0)) begin
                     st_q   <= ST_HOLD;
                     done_q <= 1'b1;
                  end else begin
                     st_q <= ST_TAIL;
                  end
               end
            end
            ST_TAIL: begin
               if (take) begin
                  cnt_q <= cnt_q + IDX_W'(1);
                  if (tail_last) begin
                     st_q   <= ST_HOLD;
                     done_q <= 1'b1;
                  end
               end
            end
            default: begin
               if (out_accept) begin
                  st_q  <= ST_OPC;
                  ill_q <= 1'b0;
               end
            end
         endcase
      end
   end

   logic show;
   assign show = (st_q == ST_HOLD) && !ill_q;

   assign out_valid    = (st_q == ST_HOLD);
   assign out_done     = done_q;
   assign out_illegal  = out_valid && ill_q;
   assign out_wide     = show && wide_q;
   assign out_dst_kind = show ? dec_q.dst_kind : K_NONE;
   assign out_src_kind = show ? dec_q.src_kind : K_NONE;
   assign out_dst_reg  = show ? dec_q.dst_reg : 3'd0;
   assign out_src_reg  = show ? dec_q.src_reg : 3'd0;
   assign out_addr     = show ? buf_addr : '0;
   assign out_imm      = show ? buf_imm : '0;
   assign out_len      = out_valid ? len_q : '0;

endmodule

// File: rtl/opx_decoder_chk.sv
module opx_decoder_chk #(
   parameter int STRICT_WIDE_REGS = 1,
   parameter int WIDE_REG_COUNT   = 5,
   parameter int FIELD_W          = 16,
   parameter int LEN_W            = 3
) (
   input logic               clk,
   input logic               rst,
   input logic               in_ready,
   input logic               out_valid,
   input logic               out_done,
   input logic               out_accept,
   input logic               out_illegal,
   input logic               out_wide,
   input logic [2:0]         out_dst_kind,
   input logic [2:0]         out_src_kind,
   input logic [2:0]         out_dst_reg,
   input logic [2:0]         out_src_reg,
   input logic [FIELD_W-1:0] out_addr,
   input logic [FIELD_W-1:0] out_imm,
   input logic [LEN_W-1:0]   out_len
);

   p_no_take_while_held_r10: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> !in_ready);

   p_record_stable_r10: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_accept) |=> (out_valid && $stable(out_addr) && $stable(out_imm)
         && $stable(out_len) && $stable(out_illegal) && $stable(out_dst_kind)
         && $stable(out_src_kind)));

   p_done_with_record_r10: assert property (@(posedge clk) disable iff (rst)
      out_done |-> out_valid);

   p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
      out_done |=> !out_done);

   p_len_range_r7: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> ((out_len >= LEN_W'(1)) && (out_len <= LEN_W'(6))));

   p_len_one_illegal_r1: assert property (@(posedge clk) disable iff (rst)
      (out_valid && (out_len == LEN_W'(1))) |-> out_illegal);

   p_illegal_clean_r8: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_illegal) |-> ((out_addr == '0) && (out_imm == '0)
         && (out_dst_kind == 3'd7) && (out_src_kind == 3'd7) && !out_wide));

   p_narrow_imm_r2: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_wide) |-> (out_imm[FIELD_W-1:FIELD_W/2] == '0));

   p_reset_idle_r11: assert property (@(posedge clk)
      rst |=> (!out_valid && in_ready && !out_done));

   generate
      if (STRICT_WIDE_REGS != 0) begin : g_wide_chk
         p_wide_dst_reg_r9: assert property (@(posedge clk) disable iff (rst)
            (out_valid && out_wide && (out_dst_kind == 3'd0))
               |-> (int'(out_dst_reg) < WIDE_REG_COUNT));
         p_wide_src_reg_r9: assert property (@(posedge clk) disable iff (rst)
            (out_valid && out_wide && (out_src_kind == 3'd0))
               |-> (int'(out_src_reg) < WIDE_REG_COUNT));
      end
   endgenerate

endmodule

bind opx_decoder opx_decoder_chk #(
   .STRICT_WIDE_REGS (STRICT_WIDE_REGS),
   .WIDE_REG_COUNT   (WIDE_REG_COUNT),
   .FIELD_W          (FIELD_W),
   .LEN_W            (LEN_W)
) i_opx_decoder_chk (
   .clk          (clk),
   .rst          (rst),
   .in_ready     (in_ready),
   .out_valid    (out_valid),
   .out_done     (out_done),
   .out_accept   (out_accept),
   .out_illegal  (out_illegal),
   .out_wide     (out_wide),
   .out_dst_kind (out_dst_kind),
   .out_src_kind (out_src_kind),
   .out_dst_reg  (out_dst_reg),
   .out_src_reg  (out_src_reg),
   .out_addr     (out_addr),
   .out_imm      (out_imm),
   .out_len      (out_len)
);

// File: tb/test_opx_decoder.sv
module test_opx_decoder;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [7:0]  in_byte = 8'h00;
   logic        in_ready;
   logic        out_valid;
   logic        out_done;
   logic        out_accept = 1'b0;
   logic        out_illegal;
   logic        out_wide;
   logic [2:0]  out_dst_kind;
   logic [2:0]  out_src_kind;
   logic [2:0]  out_dst_reg;
   logic [2:0]  out_src_reg;
   logic [15:0] out_addr;
   logic [15:0] out_imm;
   logic [2:0]  out_len;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   opx_decoder i_opx_decoder (
      .clk          (clk),
      .rst          (rst),
      .in_valid     (in_valid),
      .in_byte      (in_byte),
      .in_ready     (in_ready),
      .out_valid    (out_valid),
      .out_done     (out_done),
      .out_accept   (out_accept),
      .out_illegal  (out_illegal),
      .out_wide     (out_wide),
      .out_dst_kind (out_dst_kind),
      .out_src_kind (out_src_kind),
      .out_dst_reg  (out_dst_reg),
      .out_src_reg  (out_src_reg),
      .out_addr     (out_addr),
      .out_imm      (out_imm),
      .out_len      (out_len)
   );

   typedef struct packed {
      logic [3:0]  req;
      logic [47:0] bytes;
      logic [2:0]  n;
      logic        ill;
      logic        wide;
      logic [2:0]  dk;
      logic [2:0]  sk;
      logic [2:0]  dr;
      logic [2:0]  sr;
      logic [15:0] addr;
      logic [15:0] imm;
   } vec_t;

   localparam int NV = 24;
   localparam vec_t VECS [NV] = '{
      '{4'd3, 48'h0000_0000_0B89, 3'd2, 1'b0, 1'b1, 3'd0, 3'd0, 3'd3, 3'd1, 16'h0000, 16'h0000},
      '{4'd4, 48'h0000_1234_4788, 3'd4, 1'b0, 1'b0, 3'd0, 3'd2, 3'd7, 3'd0, 16'h1234, 16'h0000},
      '{4'd4, 48'h0000_0000_5289, 3'd2, 1'b0, 1'b1, 3'd0, 3'd3, 3'd2, 3'd0, 16'h0000, 16'h0000},
      '{4'd4, 48'h0000_ABCD_6189, 3'd4, 1'b0, 1'b1, 3'd0, 3'd4, 3'd1, 3'd0, 16'hABCD, 16'h0000},
      '{4'd2, 48'h0000_005A_4E88, 3'd3, 1'b0, 1'b0, 3'd0, 3'd1, 3'd6, 3'd0, 16'h0000, 16'h005A},
      '{4'd4, 48'h0000_1234_4889, 3'd4, 1'b0, 1'b1, 3'd0, 3'd1, 3'd0, 3'd0, 16'h0000, 16'h1234},
      '{4'd5, 48'h0000_2000_C388, 3'd4, 1'b0, 1'b0, 3'd2, 3'd0, 3'd0, 3'd3, 16'h2000, 16'h0000},
      '{4'd5, 48'h0000_0000_D489, 3'd2, 1'b0, 1'b1, 3'd3, 3'd0, 3'd0, 3'd4, 16'h0000, 16'h0000},
      '{4'd5, 48'h0000_0010_E189, 3'd4, 1'b0, 1'b1, 3'd4, 3'd0, 3'd0, 3'd1, 16'h0010, 16'h0000},
      '{4'd6, 48'h0077_3000_C888, 3'd5, 1'b0, 1'b0, 3'd2, 3'd1, 3'd0, 3'd0, 16'h3000, 16'h0077},
      '{4'd5, 48'h0000_BEEF_D889, 3'd4, 1'b0, 1'b1, 3'd3, 3'd1, 3'd0, 3'd0, 16'h0000, 16'hBEEF},
      '{4'd7, 48'h0304_0102_E889, 3'd6, 1'b0, 1'b1, 3'd4, 3'd1, 3'd0, 3'd0, 16'h0102, 16'h0304},
      '{4'd2, 48'h0004_0102_E888, 3'd5, 1'b0, 1'b0, 3'd4, 3'd1, 3'd0, 3'd0, 16'h0102, 16'h0004},
      '{4'd9, 48'h0000_0000_0D88, 3'd2, 1'b0, 1'b0, 3'd0, 3'd0, 3'd5, 3'd1, 16'h0000, 16'h0000},
      '{4'd1, 48'h0000_0000_0090, 3'd1, 1'b1, 1'b0, 3'd7, 3'd7, 3'd0, 3'd0, 16'h0000, 16'h0000},
      '{4'd1, 48'h0000_0000_008A, 3'd1, 1'b1, 1'b0, 3'd7, 3'd7, 3'd0, 3'd0, 16'h0000, 16'h0000},
      '{4'd8, 48'h0000_0000_8089, 3'd2, 1'b1, 1'b0, 3'd7, 3'd7, 3'd0, 3'd0, 16'h0000, 16'h0000},
      '{4'd8, 48'h0000_0000_C989, 3'd2, 1'b1, 1'b0, 3'd7, 3'd7, 3'd0, 3'd0, 16'h0000, 16'h0000},
      '{4'd8, 48'h0000_0000_F089, 3'd2, 1'b1, 1'b0, 3'd7, 3'd7, 3'd0, 3'd0, 16'h0000, 16'h0000},
      '{4'd8, 48'h0000_0000_5A89, 3'd2, 1'b1, 1'b0, 3'd7, 3'd7, 3'd0, 3'd0, 16'h0000, 16'h0000},
      '{4'd9, 48'h0000_0000_0D89, 3'd2, 1'b1, 1'b0, 3'd7, 3'd7, 3'd0, 3'd0, 16'h0000, 16'h0000},
      '{4'd9, 48'h0000_0000_2889, 3'd2, 1'b1, 1'b0, 3'd7, 3'd7, 3'd0, 3'd0, 16'h0000, 16'h0000},
      '{4'd9, 48'h0000_0000_C589, 3'd2, 1'b1, 1'b0, 3'd7, 3'd7, 3'd0, 3'd0, 16'h0000, 16'h0000},
      '{4'd9, 48'h0000_0000_4589, 3'd2, 1'b1, 1'b0, 3'd7, 3'd7, 3'd0, 3'd0, 16'h0000, 16'h0000}
   };

   function automatic string tag(input logic [3:0] r);
      case (r)
         4'd1:    return "R1";
         4'd2:    return "R2";
         4'd3:    return "R3";
         4'd4:    return "R4";
         4'd5:    return "R5";
         4'd6:    return "R6";
         4'd7:    return "R7";
         4'd8:    return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge after the byte was taken
   task automatic send(input logic [7:0] b);
      in_valid = 1'b1;
      in_byte  = b;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic accept_now();
      out_accept = 1'b1;
      @(negedge clk);
      out_accept = 1'b0;
   endtask

   task automatic run_vec(input vec_t v, input bit bubbles);
      string t;
      t = tag(v.req);
      for (int b = 0; b < int'(v.n); b++) begin
         if (bubbles && b > 0) begin
            @(negedge clk);
            check("R12", "no record during idle gap", {31'd0, out_valid}, 32'd0);
         end
         send(v.bytes[8*b +: 8]);
      end
      check("R10", "valid after last byte", {31'd0, out_valid}, 32'd1);
      check("R10", "done pulse with record", {31'd0, out_done}, 32'd1);
      check(t, "illegal flag", {31'd0, out_illegal}, {31'd0, v.ill});
      check("R2", "size bit", {31'd0, out_wide}, {31'd0, v.wide});
      check(t, "dst kind", {29'd0, out_dst_kind}, {29'd0, v.dk});
      check(t, "src kind", {29'd0, out_src_kind}, {29'd0, v.sk});
      check(t, "dst reg", {29'd0, out_dst_reg}, {29'd0, v.dr});
      check(t, "src reg", {29'd0, out_src_reg}, {29'd0, v.sr});
      check("R6", "address field", {16'd0, out_addr}, {16'd0, v.addr});
      check("R6", "immediate field", {16'd0, out_imm}, {16'd0, v.imm});
      check("R7", "length", {29'd0, out_len}, {29'd0, v.n});
      accept_now();
      check("R10", "record gone after accept", {31'd0, out_valid}, 32'd0);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R11 reset state
      check("R11", "valid low out of reset", {31'd0, out_valid}, 32'd0);
      check("R11", "ready high out of reset", {31'd0, in_ready}, 32'd1);
      check("R11", "no done out of reset", {31'd0, out_done}, 32'd0);

      for (int i = 0; i < NV; i++) begin
         run_vec(VECS[i], (i % 2) == 1);
      end

      // R10: record held while a stray byte waits on the input
      send(8'h89);
      send(8'h0B);
      in_valid = 1'b1;
      in_byte  = 8'h90;
      @(negedge clk);
      check("R10", "done is a single pulse", {31'd0, out_done}, 32'd0);
      check("R10", "held record still valid", {31'd0, out_valid}, 32'd1);
      check("R10", "ready low while held", {31'd0, in_ready}, 32'd0);
      repeat (3) @(negedge clk);
      check("R10", "held record unchanged", {26'd0, out_src_reg, out_dst_reg}, {26'd0, 3'd1, 3'd3});
      check("R10", "stray byte not taken", {31'd0, out_illegal}, 32'd0);
      in_valid = 1'b0;
      accept_now();
      send(8'h89);
      send(8'h52);
      check("R10", "next opcode decoded after accept", {29'd0, out_src_kind}, 32'd3);
      check("R10", "next length after accept", {29'd0, out_len}, 32'd2);
      accept_now();

      // R10: accept held high, record leaves after one cycle
      out_accept = 1'b1;
      send(8'h89);
      send(8'hD4);
      check("R10", "record shown with accept high", {31'd0, out_valid}, 32'd1);
      @(negedge clk);
      check("R10", "record taken by held accept", {31'd0, out_valid}, 32'd0);
      out_accept = 1'b0;

      // R11: reset part way through the six-byte form
      send(8'h89);
      send(8'hE8);
      send(8'h02);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check("R11", "valid low after mid reset", {31'd0, out_valid}, 32'd0);
      check("R11", "ready high after mid reset", {31'd0, in_ready}, 32'd1);
      send(8'h89);
      send(8'h0B);
      check("R11", "clean decode after reset", {31'd0, out_illegal}, 32'd0);
      check("R11", "length after reset", {29'd0, out_len}, 32'd2);
      check("R3", "reg pair after reset", {26'd0, out_src_reg, out_dst_reg}, {26'd0, 3'd1, 3'd3});
      accept_now();

      summary();
      $finish;
   end

endmodule